// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block decides how a USB device control endpoint answers each token it receives. The upstream packet decoder presents a token kind along with a one-cycle valid strobe. The endpoint's current condition is presented alongside it: halted, waiting for a buffer, or armed with a buffer. The same cycle also carries a lockout flag for setup traffic, a flag saying whether the transfer descriptor still expects further packets, and two flags that report a FIFO starving during transmit or filling up during receive.

One clock after the strobe, the block registers a 3-bit response code and raises a response-valid pulse for exactly one cycle. The code tells the packet engine which action to take. It may send a handshake (ACK, NAK, NYET, STALL), start sending data, deliberately corrupt the outgoing packet with a bit-stuff violation, or stay silent. Between responses the code holds its last value.

Top module: `ctrl_ep_responder`

## Requirements
- R1: One clock edge after a cycle with `tok_vld` high, `rsp_vld` is high for one cycle and `rsp_code` carries the answer. Otherwise `rsp_vld` is low and `rsp_code` keeps its previous value, so back-to-back tokens each get their own pulse.
- R2: After reset, and until the first token, `rsp_vld` is 0 and `rsp_code` is 0 (silent).
- R3: A SETUP token (`tok_kind` 0) with `setup_lock` low answers ACK (code 1). This holds when `ep_state` is halted (0), idle (1) or armed (2).
- R4: A SETUP token with `setup_lock` high answers silent (code 0). `setup_lock` has no effect on any other token kind.
- R5: An IN token (`tok_kind` 1) answers STALL (code 4) when halted, NAK (code 2) when idle, and transmit-data (code 5) when armed.
- R6: An OUT token (`tok_kind` 2) answers STALL when halted and NAK when idle. When armed, the data is received and the answer is ACK if `pkts_left` is 1, or NYET (code 3) if `pkts_left` is 0.
- R7: A PING token (`tok_kind` 3) answers STALL when halted, NAK when idle, and ACK when armed.
- R8: Any `tok_kind` from 4 to 7 answers silent in every state. Any non-SETUP token answers silent when `ep_state` is 3.
- R9: An armed IN token with `tx_underrun` high answers forced bit-stuff error (code 6).
- R10: An armed OUT token with `rx_overrun` high answers NAK, whatever `pkts_left` is.
- R11: An error flag has no effect on the answer when its token has no matching data phase. This covers SETUP, PING, IN with `rx_overrun`, OUT with `tx_underrun`, and any token that is not armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_vld | input | 1 | Token present this cycle |
| tok_kind | input | 3 | 0 SETUP, 1 IN, 2 OUT, 3 PING, 4-7 invalid |
| ep_state | input | 2 | 0 halted, 1 idle, 2 armed, 3 unused |
| setup_lock | input | 1 | Setup lockout active |
| pkts_left | input | 1 | Descriptor expects further packets |
| tx_underrun | input | 1 | Transmit FIFO starved |
| rx_overrun | input | 1 | Receive FIFO full |
| rsp_vld | output | 1 | One-cycle response pulse |
| rsp_code | output | 3 | 0 silent, 1 ACK, 2 NAK, 3 NYET, 4 STALL, 5 transmit, 6 bit-stuff error |

## Verification
The hardest cases to reach are combinations where several side inputs are active at once and only one of them should matter. One example is an armed OUT token that has both packets remaining and an overrun, where NAK must beat ACK. Another is an underrun flag that arrives with an OUT or PING token and must be ignored. The stimulus drives these combinations deliberately. It also sends back-to-back tokens whose answers differ, separated by idle cycles that carry noisy flags, so that each pulse is seen to be independent and the held code is seen to stay put.

// File: rtl/ctrl_ep_responder.sv
module ctrl_ep_responder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_vld,
  input  logic [2:0] tok_kind,
  input  logic [1:0] ep_state,
  input  logic       setup_lock,
  input  logic       pkts_left,
  input  logic       tx_underrun,
  input  logic       rx_overrun,
  output logic       rsp_vld,
  output logic [2:0] rsp_code
);
  localparam logic [2:0] C_SIL = 3'd0, C_ACK = 3'd1, C_NAK = 3'd2, C_NYET = 3'd3,
                         C_STALL = 3'd4, C_XMIT = 3'd5, C_BSERR = 3'd6;
  localparam logic [1:0] S_HALT = 2'd0, S_IDLE = 2'd1, S_ARMED = 2'd2;

  logic [2:0] nxt;

  always_comb begin
    nxt = C_SIL;
    if (tok_kind == 3'd0) begin
      nxt = setup_lock ? C_SIL : C_ACK;
    end else if (tok_kind <= 3'd3) begin
      case (ep_state)
        S_HALT:  nxt = C_STALL;
        S_IDLE:  nxt = C_NAK;
        S_ARMED: begin
          case (tok_kind)
            3'd1:    nxt = tx_underrun ? C_BSERR : C_XMIT;
            3'd2:    nxt = rx_overrun ? C_NAK : (pkts_left ? C_ACK : C_NYET);
            default: nxt = C_ACK;
          endcase
        end
        default: nxt = C_SIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_code <= C_SIL;
    end else begin
      rsp_vld <= tok_vld;
      if (tok_vld) rsp_code <= nxt;
    end
  end
endmodule

// File: rtl/ctrl_ep_responder_chk.sv
module ctrl_ep_responder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tok_vld,
  input logic [2:0] tok_kind,
  input logic [1:0] ep_state,
  input logic       setup_lock,
  input logic       pkts_left,
  input logic       tx_underrun,
  input logic       rx_overrun,
  input logic       rsp_vld,
  input logic [2:0] rsp_code
);
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) tok_vld |=> rsp_vld); // R1
  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !tok_vld |=> !rsp_vld); // R1
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tok_vld |=> $stable(rsp_code)); // R1
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind == 3'd0 && !setup_lock) |=> rsp_code == 3'd1); // R3
  AST_SETUP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind == 3'd0 && setup_lock) |=> rsp_code == 3'd0); // R4
  AST_HALT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind != 3'd0 && tok_kind <= 3'd3 && ep_state == 2'd0) |=> rsp_code == 3'd4); // R5
  AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind >= 3'd4) |=> rsp_code == 3'd0); // R8
  AST_UNDERRUN_BS: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind == 3'd1 && ep_state == 2'd2 && tx_underrun) |=> rsp_code == 3'd6); // R9
  AST_OVERRUN_NAK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_vld && tok_kind == 3'd2 && ep_state == 2'd2 && rx_overrun) |=> rsp_code == 3'd2); // R10
endmodule

bind ctrl_ep_responder ctrl_ep_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_kind(tok_kind), .ep_state(ep_state),
  .setup_lock(setup_lock), .pkts_left(pkts_left), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun), .rsp_vld(rsp_vld), .rsp_code(rsp_code)
);

// File: tb/sim_ctrl_ep_responder.sv
module sim_ctrl_ep_responder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_vld = 1'b0;
  logic [2:0] tok_kind = 3'd0;
  logic [1:0] ep_state = 2'd0;
  logic setup_lock = 1'b0, pkts_left = 1'b0, tx_underrun = 1'b0, rx_overrun = 1'b0;
  logic rsp_vld;
  logic [2:0] rsp_code;

  int tests = 0, fails = 0;
  logic [2:0] exp_q[$];
  string req_q[$];
  logic [2:0] last_code = 3'd0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctrl_ep_responder u0 (
    .clk(clk), .rst_n(rst_n), .tok_vld(tok_vld), .tok_kind(tok_kind), .ep_state(ep_state),
    .setup_lock(setup_lock), .pkts_left(pkts_left), .tx_underrun(tx_underrun),
    .rx_overrun(rx_overrun), .rsp_vld(rsp_vld), .rsp_code(rsp_code)
  );

  task automatic send(input logic [2:0] k, input logic [1:0] s, input logic lk, input logic pk,
                      input logic un, input logic ov, input logic [2:0] e, input string r);
    @(posedge clk); #1;
    tok_vld = 1'b1; tok_kind = k; ep_state = s;
    setup_lock = lk; pkts_left = pk; tx_underrun = un; rx_overrun = ov;
    exp_q.push_back(e); req_q.push_back(r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tok_vld = 1'b0; tok_kind = 3'(i); ep_state = 2'(i);
      setup_lock = i[0]; pkts_left = i[1]; tx_underrun = 1'b1; rx_overrun = 1'b1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rsp_vld) begin
        if (exp_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R1: unexpected rsp_vld, actual 1 expected 0");
        end else begin
          logic [2:0] e;
          string r;
          e = exp_q.pop_front(); r = req_q.pop_front();
          tests++;
          if (rsp_code !== e) begin
            fails++;
            $display("FAIL %s: rsp_code actual %0d expected %0d", r, rsp_code, e);
          end
          last_code = rsp_code;
        end
      end else if (rsp_code !== last_code) begin
        tests++; fails++;
        $display("FAIL R1: code changed while idle, actual %0d expected %0d", rsp_code, last_code);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (rsp_vld !== 1'b0 || rsp_code !== 3'd0) begin
      fails++;
      $display("FAIL R2: reset actual vld=%0b code=%0d expected vld=0 code=0", rsp_vld, rsp_code);
    end
    rst_n = 1'b1;
    idle(2);
    // R3 setup accepted in every state
    send(0, 0, 0, 0, 0, 0, 1, "R3");
    send(0, 1, 0, 0, 0, 0, 1, "R3");
    send(0, 2, 0, 1, 0, 0, 1, "R3");
    idle(1);
    // R4 lockout
    send(0, 2, 1, 0, 0, 0, 0, "R4");
    send(1, 2, 1, 0, 0, 0, 5, "R4");
    send(2, 1, 1, 0, 0, 0, 2, "R4");
    // R5 IN
    send(1, 0, 0, 0, 0, 0, 4, "R5");
    send(1, 1, 0, 0, 0, 0, 2, "R5");
    send(1, 2, 0, 0, 0, 0, 5, "R5");
    idle(3);
    // R6 OUT
    send(2, 0, 0, 1, 0, 0, 4, "R6");
    send(2, 1, 0, 1, 0, 0, 2, "R6");
    send(2, 2, 0, 1, 0, 0, 1, "R6");
    send(2, 2, 0, 0, 0, 0, 3, "R6");
    // R7 PING
    send(3, 0, 0, 0, 0, 0, 4, "R7");
    send(3, 1, 0, 0, 0, 0, 2, "R7");
    send(3, 2, 0, 0, 0, 0, 1, "R7");
    idle(2);
    // R8 invalid kinds and unused state
    for (int k = 4; k < 8; k++) send(3'(k), 2'(k), 0, 1, 1, 1, 0, "R8");
    send(1, 3, 0, 0, 0, 0, 0, "R8");
    send(2, 3, 0, 1, 0, 0, 0, "R8");
    // R9 underrun
    send(1, 2, 0, 0, 1, 0, 6, "R9");
    send(1, 2, 0, 1, 1, 1, 6, "R9");
    // R10 overrun beats ACK and NYET
    send(2, 2, 0, 1, 0, 1, 2, "R10");
    send(2, 2, 0, 0, 0, 1, 2, "R10");
    idle(1);
    // R11 flags without matching data phase
    send(0, 2, 0, 0, 1, 1, 1, "R11");
    send(3, 2, 0, 0, 1, 1, 1, "R11");
    send(1, 2, 0, 0, 0, 1, 5, "R11");
    send(2, 2, 0, 0, 1, 0, 3, "R11");
    send(1, 1, 0, 0, 1, 1, 2, "R11");
    send(2, 0, 0, 0, 1, 1, 4, "R11");
    idle(4);
    @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1: missing responses, actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL R1: watchdog expired, actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule